// File: doc/BRIEF.md
# Modem Handshake Status and Control Unit

This block is the modem-line part of a serial port's register file. It watches three low-active handshake inputs (clear-to-send, data-set-ready and carrier-detect) and brings each one into the clock domain through a short flop chain. A status byte shows the present high-true level of each line together with a sticky change flag for each line. The block drives a low-active terminal-ready output from a bit in its control byte. It also requests an interrupt when a line moves.

Software writes the control byte through a write strobe and reads either byte through its own read strobe. Reading the status byte acknowledges the change flags. Three sideband inputs come from elsewhere in the port:
- an interrupt enable for this source;
- an automatic flow-control enable, under which clear-to-send gates the transmitter and so must not interrupt;
- a loopback enable, which feeds the control bits into the status path in place of the pins, so that self-test code can drive the whole change and interrupt chain.

The interrupt request comes from a two-state machine. `IRQ_IDLE` moves to `IRQ_ASSERTED` when an interrupt-capable change flag is set and the source is enabled. `IRQ_ASSERTED` returns to `IRQ_IDLE` once no such flag remains, or once the enable is removed. Each state otherwise holds.

Top module: `modem_status_unit`

## Requirements
- R1: Status bit 4 reads 1 while `cts_n` is low, bit 5 reads 1 while `dsr_n` is low, and bit 7 reads 1 while `dcd_n` is low. A pin level reaches the status byte two clock edges after it is applied.
- R2: A level change in either direction sets a change flag: bit 0 for clear-to-send, bit 1 for data-set-ready and bit 3 for carrier-detect. The flag is set on the third clock edge after the pin moves and stays set until a status read.
- R3: A status read (`rd_status` high at a clock edge) clears every change flag at that edge. A change detected at that same edge is kept set. The value returned by a read is the value from before the clear.
- R4: Status bits 2 and 6 always read 0.
- R5: With `msi_en` high, `irq` goes high one edge after any interrupt-capable change flag is set. It goes low one edge after a status read leaves no such flag set.
- R6: While `auto_cts_en` is high, the clear-to-send change flag still sets, but on its own it never raises `irq`.
- R7: With `msi_en` low, `irq` is low from the following edge onward. Change flags are still recorded.
- R8: `dtr_n` is low only when control bit 0 is 1 and `loop_en` is low. It is high after reset.
- R9: With `loop_en` high, the status levels come from control bit 1 (clear-to-send), bit 2 (data-set-ready) and bit 3 (carrier-detect), high-true, and the pins have no effect. Changes of these bits set the change flags and can raise `irq`.
- R10: A write stores control bits 3:0, and bits 7:4 read back as 0. A control read (`rd_ctrl`) returns the control byte. Reset clears the control byte and all change flags. `rd_data` is 0 when neither read strobe is high, and status takes priority if both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, low active |
| wr_ctrl | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data |
| rd_status | input | 1 | Status read strobe; acknowledges change flags |
| rd_ctrl | input | 1 | Control read strobe |
| rd_data | output | 8 | Read data for the selected byte |
| msi_en | input | 1 | Interrupt enable for this source |
| auto_cts_en | input | 1 | Automatic clear-to-send flow control active |
| loop_en | input | 1 | Loopback self-test mode |
| cts_n | input | 1 | Clear-to-send pin, low active, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, low active, asynchronous |
| dcd_n | input | 1 | Carrier-detect pin, low active, asynchronous |
| dtr_n | output | 1 | Terminal-ready pin, low active |
| irq | output | 1 | Interrupt request, high active |

## Verification
The bench targets the read that lands on the same edge as a new change. A design that cleared without merging would lose that event, and the second read would come back with no change flag. It moves each line in both directions: a detector that catches only one polarity would miss the rising-sense flag. It then sets clear-to-send with automatic flow control on and checks that `irq` stays low, which a missing mask would break. Finally it runs loopback, toggling the pins during that mode and checking that the status holds, and confirms that terminal-ready is forced inactive there. An unmasked source mux or a missing loop term in the output would show as a wrong status byte or a low `dtr_n`.

// File: rtl/msu_pkg.sv
package msu_pkg;

    localparam int NLINES  = 3;
    localparam int LN_CTS  = 0;
    localparam int LN_DSR  = 1;
    localparam int LN_DCD  = 2;

    // status byte bit positions
    localparam int ST_DCTS = 0;
    localparam int ST_DDSR = 1;
    localparam int ST_DDCD = 3;
    localparam int ST_CTS  = 4;
    localparam int ST_DSR  = 5;
    localparam int ST_DCD  = 7;

    // control byte bit positions
    localparam int CT_DTR  = 0;
    localparam int CT_LCTS = 1;
    localparam int CT_LDSR = 2;
    localparam int CT_LDCD = 3;
    localparam int CTRL_USED = 4;

    typedef enum logic [0:0] {
        IRQ_IDLE     = 1'b0,
        IRQ_ASSERTED = 1'b1
    } irq_state_t;

endpackage

// File: rtl/msu_sync.sv
module msu_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/msu_delta.sv
module msu_delta #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic         ack,
    output logic [N-1:0] lvl_prev,
    output logic [N-1:0] delta
);
    logic [N-1:0] change;

    assign change = lvl ^ lvl_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_prev <= '0;
            delta    <= '0;
        end else begin
            lvl_prev <= lvl;
            // acknowledge clears, a change at the same edge survives
            delta    <= (delta & {N{~ack}}) | change;
        end
    end
endmodule

// File: rtl/msu_irq_fsm.sv
module msu_irq_fsm
    import msu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_en,
    input  logic              auto_cts_en,
    input  logic [NLINES-1:0] delta,
    output logic              irq
);
    irq_state_t   state_q, state_d;
    logic [NLINES-1:0] mask;
    logic         pending;

    always_comb begin
        mask         = '1;
        mask[LN_CTS] = ~auto_cts_en;
    end

    assign pending = msi_en && ((delta & mask) != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:     if (pending)  state_d = IRQ_ASSERTED;
            IRQ_ASSERTED: if (!pending) state_d = IRQ_IDLE;
            default:      state_d = IRQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            IRQ_ASSERTED: irq = 1'b1;
            default:      irq = 1'b0;
        endcase
    end
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
    import msu_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_status,
    input  logic              rd_ctrl,
    output logic [DATA_W-1:0] rd_data,
    input  logic              msi_en,
    input  logic              auto_cts_en,
    input  logic              loop_en,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              dcd_n,
    output logic              dtr_n,
    output logic              irq
);
    localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << CTRL_USED) - 1);

    logic [DATA_W-1:0] ctrl_q;
    logic [NLINES-1:0] pins_n, pins_s, lvl_pin, lvl_loop, lvl, lvl_prev, delta;
    logic [DATA_W-1:0] status;

    assign pins_n = {dcd_n, dsr_n, cts_n};

    for (genvar i = 0; i < NLINES; i++) begin : g_sync
        msu_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (pins_n[i]),
            .q    (pins_s[i])
        );
    end

    assign lvl_pin  = ~pins_s;
    assign lvl_loop = {ctrl_q[CT_LDCD], ctrl_q[CT_LDSR], ctrl_q[CT_LCTS]};
    assign lvl      = loop_en ? lvl_loop : lvl_pin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wr_data & CTRL_MASK;
        end
    end

    msu_delta #(.N(NLINES)) u_delta (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl),
        .ack     (rd_status),
        .lvl_prev(lvl_prev),
        .delta   (delta)
    );

    msu_irq_fsm u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .msi_en     (msi_en),
        .auto_cts_en(auto_cts_en),
        .delta      (delta),
        .irq        (irq)
    );

    always_comb begin
        status          = '0;
        status[ST_DCTS] = delta[LN_CTS];
        status[ST_DDSR] = delta[LN_DSR];
        status[ST_DDCD] = delta[LN_DCD];
        status[ST_CTS]  = lvl[LN_CTS];
        status[ST_DSR]  = lvl[LN_DSR];
        status[ST_DCD]  = lvl[LN_DCD];
    end

    always_comb begin
        if (rd_status)    rd_data = status;
        else if (rd_ctrl) rd_data = ctrl_q;
        else              rd_data = '0;
    end

    assign dtr_n = ~(ctrl_q[CT_DTR] & ~loop_en);
endmodule

// File: rtl/msu_checker.sv
module msu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_status,
    input logic [7:0] rd_data,
    input logic       msi_en,
    input logic       auto_cts_en,
    input logic       loop_en,
    input logic       irq,
    input logic       dtr_n,
    input logic [2:0] lvl,
    input logic [2:0] lvl_prev,
    input logic [2:0] delta
);
    a_r2_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl ^ lvl_prev) != 3'b0) |=>
        ((delta & $past(lvl ^ lvl_prev)) == $past(lvl ^ lvl_prev)));

    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && ((lvl ^ lvl_prev) == 3'b0)) |=> (delta == 3'b0));

    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |-> (rd_data[2] == 1'b0 && rd_data[6] == 1'b0));

    a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(msi_en && (delta != 3'b0)));

    a_r5_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && ((lvl ^ lvl_prev) == 3'b0)) |=> ##1 !irq);

    a_r6_autocts_masked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(!(auto_cts_en && delta[2:1] == 2'b00)));

    a_r7_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_en |=> !irq);

    a_r8_dtr_loop: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> dtr_n);
endmodule

bind modem_status_unit msu_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_status  (rd_status),
    .rd_data    (rd_data),
    .msi_en     (msi_en),
    .auto_cts_en(auto_cts_en),
    .loop_en    (loop_en),
    .irq        (irq),
    .dtr_n      (dtr_n),
    .lvl        (lvl),
    .lvl_prev   (lvl_prev),
    .delta      (delta)
);

// File: tb/modem_status_unit_test.sv
module modem_status_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_status = 1'b0;
    logic       rd_ctrl = 1'b0;
    logic [7:0] rd_data;
    logic       msi_en = 1'b0;
    logic       auto_cts_en = 1'b0;
    logic       loop_en = 1'b0;
    logic       cts_n = 1'b1;
    logic       dsr_n = 1'b1;
    logic       dcd_n = 1'b1;
    logic       dtr_n;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    modem_status_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
        .rd_status(rd_status), .rd_ctrl(rd_ctrl), .rd_data(rd_data),
        .msi_en(msi_en), .auto_cts_en(auto_cts_en), .loop_en(loop_en),
        .cts_n(cts_n), .dsr_n(dsr_n), .dcd_n(dcd_n), .dtr_n(dtr_n), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // driver: queue the expected byte, then strobe one read cycle
    task automatic do_read(input bit status_sel, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        if (status_sel) rd_status = 1'b1; else rd_ctrl = 1'b1;
        @(negedge clk);
        rd_status = 1'b0;
        rd_ctrl   = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_ctrl = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_ctrl = 1'b0;
    endtask

    // monitor: compare mid-cycle while a read strobe is high
    always @(negedge clk) begin
        #5;
        if (rd_status || rd_ctrl) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10: unexpected read actual=%02h expected=none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        settle(2);
        rst_n = 1'b1;
        settle(2);
        // reset state
        check("R8 dtr_n after reset", {7'b0, dtr_n}, 8'h01);
        check("R5 irq after reset", {7'b0, irq}, 8'h00);
        check("R10 idle rd_data", rd_data, 8'h00);
        do_read(1'b1, 8'h00, "R4 R10 status after reset");
        do_read(1'b0, 8'h00, "R10 ctrl after reset");

        // clear-to-send asserts
        msi_en = 1'b1;
        cts_n  = 1'b0;
        settle(4);
        check("R5 irq raised", {7'b0, irq}, 8'h01);
        do_read(1'b1, 8'h11, "R1 R2 cts level+delta");
        settle(2);
        check("R5 irq dropped after read", {7'b0, irq}, 8'h00);
        do_read(1'b1, 8'h10, "R3 delta cleared");

        // two lines at once
        dsr_n = 1'b0;
        dcd_n = 1'b0;
        settle(4);
        do_read(1'b1, 8'hBA, "R1 R2 R4 dsr+dcd");

        // deassert direction
        cts_n = 1'b1;
        settle(4);
        do_read(1'b1, 8'hA1, "R2 cts release");

        // automatic flow control masks clear-to-send
        auto_cts_en = 1'b1;
        cts_n = 1'b0;
        settle(4);
        check("R6 no irq in auto-cts", {7'b0, irq}, 8'h00);
        do_read(1'b1, 8'hB1, "R6 delta still set");
        auto_cts_en = 1'b0;

        // source disabled
        msi_en = 1'b0;
        dsr_n = 1'b1;
        settle(4);
        check("R7 no irq when disabled", {7'b0, irq}, 8'h00);
        do_read(1'b1, 8'h92, "R7 delta recorded");
        msi_en = 1'b1;
        settle(2);

        // change detected at the read edge is kept
        @(negedge clk);
        dcd_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        do_read(1'b1, 8'h10, "R3 read at change edge");
        settle(2);
        check("R3 R5 irq from kept change", {7'b0, irq}, 8'h01);
        do_read(1'b1, 8'h18, "R3 kept delta");
        settle(2);
        check("R5 irq dropped", {7'b0, irq}, 8'h00);

        // control byte and terminal-ready
        do_write(8'hF1);
        settle(1);
        check("R8 dtr_n active", {7'b0, dtr_n}, 8'h00);
        do_read(1'b0, 8'h01, "R10 ctrl masked readback");

        // loopback
        loop_en = 1'b1;
        settle(1);
        check("R8 dtr_n forced off in loop", {7'b0, dtr_n}, 8'h01);
        settle(3);
        do_read(1'b1, 8'h01, "R9 loop entry");
        do_write(8'hFD);
        cts_n = 1'b1;
        dsr_n = 1'b0;
        settle(4);
        check("R9 irq from loop bits", {7'b0, irq}, 8'h01);
        do_read(1'b1, 8'hAA, "R9 loop levels");
        settle(2);
        check("R9 irq dropped", {7'b0, irq}, 8'h00);
        do_read(1'b1, 8'hA0, "R9 pins ignored");

        // back to pins
        loop_en = 1'b0;
        settle(1);
        check("R8 dtr_n after loop", {7'b0, dtr_n}, 8'h00);
        settle(3);
        do_read(1'b1, 8'h28, "R9 return to pins");

        settle(2);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10: pending reads actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule